// File: doc/BRIEF.md
# Sobel Edge Magnitude Kernel

This block turns a 3x3 neighbourhood of 8-bit pixels into a single 8-bit edge pixel. It estimates the intensity slope across the window in the horizontal and in the vertical direction, limits each slope to the pixel range, and adds the two limited values into an edge weight. It then subtracts that weight from full white, so strong edges come out dark and flat areas come out white.

An upstream line-buffer stage supplies one window per clock, together with the image row and column of the centre pixel and a valid strobe. The block is a two-stage pipeline. It accepts a new window on every clock and returns each result a fixed two cycles later, with its own valid and border flags. The default image size is 512 by 512. A window whose centre lies on the outermost ring of the image is not filtered: it is flagged as border and comes out white.

Top module: `sobel_edge_core`

## Requirements
- R1: Window tap p (row r = p/3, column c = p%3, r = 0 is the top row) sits at bits [8p+7:8p] of `in_win`. The horizontal gradient is gx = (p2 + 2·p5 + p8) − (p0 + 2·p3 + p6). The vertical gradient is gy = (p6 + 2·p7 + p8) − (p0 + 2·p1 + p2). Both are signed and span ±1020.
- R2: A negative directional gradient is limited to 0 before the two are combined, independently for each direction.
- R3: A directional gradient above 255 is limited to 255 before the two are combined, independently for each direction.
- R4: For a non-border window whose edge weight w (the sum of the two limited gradients) is at most 255, `out_pix` = 255 − w.
- R5: For a non-border window with w > 255, `out_pix` = 0; the output never wraps below zero.
- R6: A window whose row is 0 or IMG_ROWS−1, or whose column is 0 or IMG_COLS−1, produces `out_border` = 1 and `out_pix` = 255, whatever the pixel values. All other windows produce `out_border` = 0.
- R7: A window presented with `in_valid` = 1 at clock edge k gives `out_valid` = 1 with its result after edge k+2. A cycle with `in_valid` = 0 gives `out_valid` = 0 two edges later.
- R8: Windows presented on consecutive cycles each give their own result on consecutive cycles, in order, with no stall.
- R9: While `rst_n` is low, and on the first two edges after it is released with no valid input, `out_valid` = 0, `out_border` = 0 and `out_pix` = 255. An assertion of `rst_n` during traffic discards windows that are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window on `in_win` is valid this cycle |
| in_win | input | 72 | Nine 8-bit taps, tap p at bits [8p+7:8p] |
| in_row | input | 9 | Image row of the window centre |
| in_col | input | 9 | Image column of the window centre |
| out_valid | output | 1 | Result on `out_pix` is valid |
| out_pix | output | 8 | Inverted edge pixel |
| out_border | output | 1 | Result belongs to a border position |

## Verification
Every result is due exactly two rising edges after the edge that captures its window. The first edge loads the gradient register and the second loads the output register. The bench drives inputs on falling edges. The result of the window driven at falling edge n is therefore read at falling edge n+2, which is where the stream loop and the directed single-window and reset tests take their samples. The single-window test also checks that `out_valid` is low one cycle before and one cycle after the due cycle.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int WIN_DIM  = 3;
    localparam int WIN_TAPS = WIN_DIM * WIN_DIM;

    // Weight of tap (r, c) in the horizontal slope kernel: column difference,
    // doubled on the centre row.
    function automatic int horiz_weight(input int r, input int c);
        int scale;
        scale = (r == 1) ? 2 : 1;
        return (c - 1) * scale;
    endfunction

    // Vertical kernel is the transpose of the horizontal one.
    function automatic int vert_weight(input int r, input int c);
        return horiz_weight(c, r);
    endfunction

endpackage

// File: rtl/sobel_grad.sv
module sobel_grad
    import sobel_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 4
) (
    input  logic [WIN_TAPS*PIX_W-1:0]  win,
    output logic signed [GRAD_W-1:0]   grad_x,
    output logic signed [GRAD_W-1:0]   grad_y
);

    localparam int PAD = GRAD_W - PIX_W;
    localparam logic signed [GRAD_W-1:0] LIMIT = GRAD_W'(4 * ((1 << PIX_W) - 1));

    logic signed [GRAD_W-1:0] term_x [WIN_TAPS];
    logic signed [GRAD_W-1:0] term_y [WIN_TAPS];

    for (genvar t = 0; t < WIN_TAPS; t++) begin : g_tap
        localparam int R = t / WIN_DIM;
        localparam int C = t % WIN_DIM;
        localparam logic signed [GRAD_W-1:0] WX = GRAD_W'(horiz_weight(R, C));
        localparam logic signed [GRAD_W-1:0] WY = GRAD_W'(vert_weight(R, C));
        logic signed [GRAD_W-1:0] px;
        assign px        = $signed({{PAD{1'b0}}, win[t*PIX_W +: PIX_W]});
        assign term_x[t] = px * WX;
        assign term_y[t] = px * WY;
    end

    always_comb begin
        grad_x = '0;
        grad_y = '0;
        for (int t = 0; t < WIN_TAPS; t++) begin
            grad_x = grad_x + term_x[t];
            grad_y = grad_y + term_y[t];
        end
    end

    // R1: slope sums stay inside the range the kernels allow
    always_comb begin
        if (!$isunknown(win)) begin
            assert_grad_range_R1: assert (grad_x >= -LIMIT && grad_x <= LIMIT &&
                                          grad_y >= -LIMIT && grad_y <= LIMIT);
        end
    end

endmodule

// File: rtl/sobel_border.sv
module sobel_border #(
    parameter int IMG_ROWS = 512,
    parameter int IMG_COLS = 512,
    parameter int ROW_W    = $clog2(IMG_ROWS),
    parameter int COL_W    = $clog2(IMG_COLS)
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             on_edge
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_COLS - 1);

    always_comb begin
        on_edge = (row == '0) || (row == LAST_ROW) ||
                  (col == '0) || (col == LAST_COL);
    end

endmodule

// File: rtl/sobel_combine.sv
module sobel_combine #(
    parameter int PIX_W  = 8,
    parameter int GRAD_W = PIX_W + 4
) (
    input  logic signed [GRAD_W-1:0] grad_x,
    input  logic signed [GRAD_W-1:0] grad_y,
    input  logic                     border,
    output logic [PIX_W-1:0]         pix
);

    localparam logic [PIX_W-1:0]         WHITE   = '1;
    localparam logic signed [GRAD_W-1:0] WHITE_S = GRAD_W'(2 ** PIX_W - 1);

    function automatic logic [PIX_W-1:0] bound(input logic signed [GRAD_W-1:0] g);
        if (g < 0)
            return '0;
        else if (g > WHITE_S)
            return WHITE;
        else
            return g[PIX_W-1:0];
    endfunction

    logic [PIX_W-1:0] lim_x;
    logic [PIX_W-1:0] lim_y;
    logic [PIX_W:0]   weight;

    always_comb begin
        lim_x  = bound(grad_x);
        lim_y  = bound(grad_y);
        weight = {1'b0, lim_x} + {1'b0, lim_y};
        if (border)
            pix = WHITE;
        else if (weight > {1'b0, WHITE})
            pix = '0;
        else
            pix = WHITE - weight[PIX_W-1:0];
    end

    always_comb begin
        if (!$isunknown({grad_x, grad_y, border}) && !border) begin
            // R4: output and weight add up to white
            if (weight <= {1'b0, WHITE})
                assert_invert_R4: assert (({1'b0, pix} + weight) == {1'b0, WHITE});
            // R5: saturated weight gives black, never a wrapped value
            else
                assert_floor_R5: assert (pix == '0);
        end
    end

endmodule

// File: rtl/sobel_edge_core.sv
module sobel_edge_core
    import sobel_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int IMG_ROWS = 512,
    parameter int IMG_COLS = 512,
    localparam int ROW_W   = $clog2(IMG_ROWS),
    localparam int COL_W   = $clog2(IMG_COLS),
    localparam int WIN_W   = WIN_TAPS * PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    input  logic [ROW_W-1:0] in_row,
    input  logic [COL_W-1:0] in_col,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_border
);

    localparam int GRAD_W = PIX_W + 4;

    typedef struct packed {
        logic                     valid;
        logic                     border;
        logic signed [GRAD_W-1:0] gx;
        logic signed [GRAD_W-1:0] gy;
    } slope_stage_t;

    typedef struct packed {
        logic             valid;
        logic             border;
        logic [PIX_W-1:0] pix;
    } pixel_stage_t;

    typedef struct packed {
        slope_stage_t s1;
        pixel_stage_t s2;
    } pipe_t;

    localparam pipe_t PIPE_RESET = '{
        s1: '{valid: 1'b0, border: 1'b0, gx: '0, gy: '0},
        s2: '{valid: 1'b0, border: 1'b0, pix: '1}
    };

    logic signed [GRAD_W-1:0] grad_x_w;
    logic signed [GRAD_W-1:0] grad_y_w;
    logic                     edge_w;
    logic [PIX_W-1:0]         pix_w;

    pipe_t pipe_d, pipe_q;

    sobel_grad #(.PIX_W(PIX_W), .GRAD_W(GRAD_W)) u_grad (
        .win    (in_win),
        .grad_x (grad_x_w),
        .grad_y (grad_y_w)
    );

    sobel_border #(
        .IMG_ROWS (IMG_ROWS),
        .IMG_COLS (IMG_COLS),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W)
    ) u_border (
        .row     (in_row),
        .col     (in_col),
        .on_edge (edge_w)
    );

    sobel_combine #(.PIX_W(PIX_W), .GRAD_W(GRAD_W)) u_combine (
        .grad_x (pipe_q.s1.gx),
        .grad_y (pipe_q.s1.gy),
        .border (pipe_q.s1.border),
        .pix    (pix_w)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.valid = in_valid;
        if (in_valid) begin
            pipe_d.s1.border = edge_w;
            pipe_d.s1.gx     = grad_x_w;
            pipe_d.s1.gy     = grad_y_w;
        end
        pipe_d.s2.valid = pipe_q.s1.valid;
        if (pipe_q.s1.valid) begin
            pipe_d.s2.border = pipe_q.s1.border;
            pipe_d.s2.pix    = pix_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pipe_q <= PIPE_RESET;
        else
            pipe_q <= pipe_d;
    end

    assign out_valid  = pipe_q.s2.valid;
    assign out_pix    = pipe_q.s2.pix;
    assign out_border = pipe_q.s2.border;

    // R7: accepted window reaches the slope register one edge later
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pipe_q.s1.valid);

    // R7: an idle input cycle leaves no result in the slope register
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !pipe_q.s1.valid);

    // R8: slope stage result is always forwarded to the output on the next edge
    assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.valid |=> out_valid);

    // R6: border results leave as white
    assert_border_white_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_border) |-> (out_pix == '1));

    // R9: no result is presented on the edge that ends reset
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && !out_border));

endmodule

// File: tb/sobel_edge_core_bench.sv
module sobel_edge_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [71:0] in_win;
    logic [8:0]  in_row;
    logic [8:0]  in_col;
    logic        out_valid;
    logic [7:0]  out_pix;
    logic        out_border;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sobel_edge_core u_sobel_edge_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_win     (in_win),
        .in_row     (in_row),
        .in_col     (in_col),
        .out_valid  (out_valid),
        .out_pix    (out_pix),
        .out_border (out_border)
    );

    // Taps written p8 (left) .. p0 (right), one byte each.
    localparam logic [71:0] V_WIN [NV] = '{
        72'h646464646464646464,  // flat: gx 0, gy 0
        72'h0A05000A05000A0500,  // gx 40, gy 0
        72'h141414000000000000,  // gx 0, gy 80
        72'h000032000032000032,  // gx -200 -> 0, gy 0
        72'hFF0000FF0000FF0000,  // gx 1020 -> 255, gy 0
        72'h320000000000000000,  // gx 50, gy 50
        72'hC80000000000000000,  // gx 200, gy 200: weight 400
        72'hFFFF00FF0000000000,  // gx 765, gy 765 both bounded
        72'h000000000000640000,  // gx 100, gy -100 -> 0
        72'h0000000000000000FF,  // both negative
        72'h320000000000000000,  // row 0
        72'h320000000000000000,  // last column
        72'h320000000000000000,  // last row
        72'h320000000000000000   // column 0
    };
    localparam logic [8:0] V_ROW [NV] = '{9'd100, 9'd100, 9'd100, 9'd100, 9'd100,
        9'd100, 9'd100, 9'd100, 9'd1, 9'd510, 9'd0, 9'd200, 9'd511, 9'd300};
    localparam logic [8:0] V_COL [NV] = '{9'd200, 9'd200, 9'd200, 9'd200, 9'd200,
        9'd200, 9'd200, 9'd200, 9'd1, 9'd510, 9'd100, 9'd511, 9'd50, 9'd0};
    localparam logic [7:0] V_PIX [NV] = '{8'd255, 8'd215, 8'd175, 8'd255, 8'd0,
        8'd155, 8'd0, 8'd0, 8'd155, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255};
    localparam logic V_BRD [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam string V_REQ [NV] = '{"R1", "R1", "R1", "R2", "R3", "R4", "R5",
        "R3", "R2", "R2", "R6", "R6", "R6", "R6"};

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        in_win   = '0;
        in_row   = 9'd100;
        in_col   = 9'd100;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R9: state held in reset
        check(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
        check(out_pix == 8'd255, "R9", "reset out_pix", int'(out_pix), 255);
        check(out_border == 1'b0, "R9", "reset out_border", int'(out_border), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R9", "idle after reset", int'(out_valid), 0);

        // R8: back-to-back stream, each result due two edges after capture
        for (int j = 0; j < NV + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                check(out_valid == 1'b1, V_REQ[j-2], "valid", int'(out_valid), 1);
                check(out_pix == V_PIX[j-2], V_REQ[j-2], "pix",
                      int'(out_pix), int'(V_PIX[j-2]));
                check(out_border == V_BRD[j-2], V_REQ[j-2], "border",
                      int'(out_border), int'(V_BRD[j-2]));
            end
            if (j < NV) begin
                in_valid = 1'b1;
                in_win   = V_WIN[j];
                in_row   = V_ROW[j];
                in_col   = V_COL[j];
            end else begin
                idle_inputs();
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "stream drained", int'(out_valid), 0);

        // R7: single window, exact due cycle
        in_valid = 1'b1;
        in_win   = 72'h320000000000000000;
        in_row   = 9'd7;
        in_col   = 9'd9;
        @(negedge clk);
        idle_inputs();
        in_win = 72'hC80000000000000000;  // ignored: not valid
        check(out_valid == 1'b0, "R7", "one cycle early", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7", "due cycle valid", int'(out_valid), 1);
        check(out_pix == 8'd155, "R7", "due cycle pix", int'(out_pix), 155);
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "one cycle late", int'(out_valid), 0);
        check(out_pix == 8'd155, "R7", "held pix", int'(out_pix), 155);

        // R9: reset during traffic discards windows in flight
        in_valid = 1'b1;
        in_win   = 72'hFF0000FF0000FF0000;
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        #1;
        check(out_valid == 1'b0, "R9", "async clear", int'(out_valid), 0);
        check(out_pix == 8'd255, "R9", "async clear pix", int'(out_pix), 255);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "flushed 1", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "flushed 2", int'(out_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule